// File: doc/BRIEF.md
# Fail-on-First Vector Length Truncator

This block sits after the element lanes of a vectorised operation. It decides how many leading elements may keep their results. In load mode an element fails when its memory access was illegal, for example a fault on crossing a page boundary. In ALU mode an element fails when its result is zero. Fail-on-first truncation is active only while the enable bit is set. When it is active, the new vector length is the index of the lowest failing element. All elements below that index commit normally, so the operation never drops to a scalar sequence.

Since the maximum vector length is a run-time value, each operation supplies it. The reported length never exceeds it. The per-element flags arrive in one of two forms, chosen by `bulk` at `start`:

- As two whole vectors, one of fault flags and one of zero flags. A priority encoder then gives the result one cycle after `start`.
- One element per `elem_valid` cycle, in element order. The result then appears one cycle after the element that settles it.

The controller has three states:

- IDLE waits for `start`.
- COLLECT consumes element flags in order.
- REPORT holds `done` high for one cycle.

It has four transitions:

- IDLE→REPORT, on a bulk start or a zero limit.
- IDLE→COLLECT, on an element-order start with a non-zero limit.
- COLLECT→REPORT, on a failing element or on the last element inside the limit.
- REPORT→IDLE, always.

Top module: `fof_truncator`

## Requirements
- R1: The limit is min(`vl_in`, `mvl_in`, 64). The reported `vl_out` never exceeds it. With no failure inside the limit, `vl_out` equals the limit.
- R2: Load mode (`mode_alu`=0): `vl_out` is the index of the lowest set `fault` flag below the limit. `zero` flags are ignored.
- R3: ALU mode (`mode_alu`=1): `vl_out` is the index of the lowest set `zero` flag below the limit. `fault` flags are ignored.
- R4: With `ff_en`=0 no flag truncates, and `vl_out` equals the limit.
- R5: Flags at element indices at or above the limit have no effect.
- R6: A failure at element 0 gives `vl_out`=0 and `commit_mask`=0.
- R7: `commit_mask` bit i is 1 exactly when i < `vl_out`.
- R8: Bulk form (`bulk`=1 at `start`): `done` is high in the cycle after `start`.
- R9: Element form (`bulk`=0): the element with index k is read in each cycle where `elem_valid` is high, for k = 0, 1, 2 and so on. `done` goes high in the cycle after the first failing element or after element limit-1, whichever comes first. With a limit of 0, `done` goes high in the cycle after `start`.
- R10: `done` is a one-cycle pulse. `vl_out` and `commit_mask` hold their values until the next `done`.
- R11: `start` is ignored while `busy` is high.
- R12: After reset, `busy`=0, `done`=0, `vl_out`=0 and `commit_mask`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one operation (accepted only when idle) |
| bulk | input | 1 | 1: flags given as vectors; 0: flags streamed per element |
| mode_alu | input | 1 | 0: load faults fail; 1: zero results fail |
| ff_en | input | 1 | Fail-on-first enable |
| vl_in | input | 7 | Incoming vector length |
| mvl_in | input | 7 | Current maximum vector length |
| fault_vec | input | 64 | Per-element illegal-access flags (bulk form) |
| zero_vec | input | 64 | Per-element result-is-zero flags (bulk form) |
| elem_valid | input | 1 | Streamed element flags valid this cycle |
| elem_fault | input | 1 | Streamed element illegal-access flag |
| elem_zero | input | 1 | Streamed element result-is-zero flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| vl_out | output | 7 | Truncated vector length |
| commit_mask | output | 64 | Per-element commit enables |

## Verification
The assertions check four things on every cycle:

- The reported length stays within the limit captured at the accepted start.
- With fail-on-first disabled, the length is exactly that limit.
- The commit mask is a contiguous run of low ones whose population equals the length.
- `done` is a single pulse, arrives one cycle after a bulk start, and the length holds between pulses.

Only the bench's scenarios show the rest:

- Which element actually wins the priority encoding.
- That the unselected flag kind is ignored.
- That flags above the limit have no effect.
- The exact completion cycle in element-order streams.
- That a start issued mid-stream is dropped.

// File: rtl/fof_pkg.sv
package fof_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_REPORT  = 2'd2
    } fof_state_e;

    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_ALU  = 1'b1
    } fof_mode_e;
endpackage

// File: rtl/fof_fail_select.sv
// Builds the per-element failure vector: picks the flag kind by mode,
// gates it with the enable, and drops elements at or beyond the limit.
module fof_fail_select
    import fof_pkg::*;
#(
    parameter int N  = 64,
    parameter int VW = 7
) (
    input  fof_mode_e         mode,
    input  logic              ff_en,
    input  logic [VW-1:0]     limit,
    input  logic [N-1:0]      fault_vec,
    input  logic [N-1:0]      zero_vec,
    output logic [N-1:0]      fail_vec
);
    for (genvar i = 0; i < N; i++) begin : g_elem
        localparam logic [VW-1:0] IDX = VW'(i);
        logic flag;
        assign flag        = (mode == MODE_ALU) ? zero_vec[i] : fault_vec[i];
        assign fail_vec[i] = ff_en && flag && (IDX < limit);
    end
endmodule

// File: rtl/fof_prio_enc.sv
// Lowest-index-wins priority encoder.
module fof_prio_enc #(
    parameter int N  = 64,
    parameter int VW = 7
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [VW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = VW'(i);
            end
        end
    end
endmodule

// File: rtl/fof_mask_gen.sv
// Thermometer mask: bit i set when i is below the length.
module fof_mask_gen #(
    parameter int N  = 64,
    parameter int VW = 7
) (
    input  logic [VW-1:0] len,
    output logic [N-1:0]  mask
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam logic [VW-1:0] IDX = VW'(i);
        assign mask[i] = (IDX < len);
    end
endmodule

// File: rtl/fof_truncator.sv
module fof_truncator
    import fof_pkg::*;
#(
    parameter  int N  = 64,
    localparam int VW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          bulk,
    input  logic          mode_alu,
    input  logic          ff_en,
    input  logic [VW-1:0] vl_in,
    input  logic [VW-1:0] mvl_in,
    input  logic [N-1:0]  fault_vec,
    input  logic [N-1:0]  zero_vec,
    input  logic          elem_valid,
    input  logic          elem_fault,
    input  logic          elem_zero,
    output logic          busy,
    output logic          done,
    output logic [VW-1:0] vl_out,
    output logic [N-1:0]  commit_mask
);
    fof_state_e    state_q, state_d;
    fof_mode_e     mode_q;
    logic          ff_q;
    logic [VW-1:0] lim_q;
    logic [VW-1:0] idx_q;
    logic [VW-1:0] vl_q;

    // Limit of this operation: min(vl, mvl, N)
    logic [VW-1:0] lim_now;
    always_comb begin
        lim_now = (vl_in < mvl_in) ? vl_in : mvl_in;
        if (lim_now > VW'(N)) begin
            lim_now = VW'(N);
        end
    end

    // Bulk path: mask, then priority-encode
    logic [N-1:0]  bulk_fail;
    logic          bulk_found;
    logic [VW-1:0] bulk_idx;

    fof_fail_select #(.N(N), .VW(VW)) u_sel (
        .mode      (fof_mode_e'(mode_alu)),
        .ff_en     (ff_en),
        .limit     (lim_now),
        .fault_vec (fault_vec),
        .zero_vec  (zero_vec),
        .fail_vec  (bulk_fail)
    );

    fof_prio_enc #(.N(N), .VW(VW)) u_enc (
        .vec   (bulk_fail),
        .found (bulk_found),
        .idx   (bulk_idx)
    );

    // Streamed path: one element per valid cycle
    logic elem_fail;
    logic last_elem;
    assign elem_fail = ff_q && ((mode_q == MODE_ALU) ? elem_zero : elem_fault);
    assign last_elem = ((idx_q + VW'(1)) == lim_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (bulk || (lim_now == '0)) ? ST_REPORT : ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (elem_valid && (elem_fail || last_elem)) begin
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_LOAD;
            ff_q    <= 1'b0;
            lim_q   <= '0;
            idx_q   <= '0;
            vl_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q <= fof_mode_e'(mode_alu);
                        ff_q   <= ff_en;
                        lim_q  <= lim_now;
                        idx_q  <= '0;
                        if (bulk) begin
                            vl_q <= bulk_found ? bulk_idx : lim_now;
                        end else if (lim_now == '0) begin
                            vl_q <= '0;
                        end
                    end
                end
                ST_COLLECT: begin
                    if (elem_valid) begin
                        if (elem_fail) begin
                            vl_q <= idx_q;
                        end else if (last_elem) begin
                            vl_q <= lim_q;
                        end
                        idx_q <= idx_q + VW'(1);
                    end
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done   = (state_q == ST_REPORT);
        busy   = (state_q != ST_IDLE);
        vl_out = vl_q;
    end

    fof_mask_gen #(.N(N), .VW(VW)) u_mask (
        .len  (vl_q),
        .mask (commit_mask)
    );
endmodule

// File: rtl/fof_truncator_chk.sv
module fof_truncator_chk #(
    parameter int N  = 64,
    parameter int VW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          bulk,
    input logic          ff_en,
    input logic [VW-1:0] vl_in,
    input logic [VW-1:0] mvl_in,
    input logic          busy,
    input logic          done,
    input logic [VW-1:0] vl_out,
    input logic [N-1:0]  commit_mask
);
    logic [VW-1:0] lim_cap;
    logic          ff_cap;
    logic [VW-1:0] lim_ref;

    always_comb begin
        lim_ref = (vl_in < mvl_in) ? vl_in : mvl_in;
        if (lim_ref > VW'(N)) lim_ref = VW'(N);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_cap <= '0;
            ff_cap  <= 1'b0;
        end else if (start && !busy) begin
            lim_cap <= lim_ref;
            ff_cap  <= ff_en;
        end
    end

    a_r1_vl_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= lim_cap));

    a_r4_bypass_keeps_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ff_cap) |-> (vl_out == lim_cap));

    a_r7_mask_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(commit_mask) == int'(vl_out)));

    a_r7_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((commit_mask & (commit_mask + N'(1))) == '0));

    a_r8_bulk_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bulk) |=> done);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(vl_out));
endmodule

bind fof_truncator fof_truncator_chk #(.N(N), .VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .bulk        (bulk),
    .ff_en       (ff_en),
    .vl_in       (vl_in),
    .mvl_in      (mvl_in),
    .busy        (busy),
    .done        (done),
    .vl_out      (vl_out),
    .commit_mask (commit_mask)
);

// File: tb/tb_fof_truncator.sv
`timescale 1ns/1ps
module tb_fof_truncator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, bulk = 1'b0, mode_alu = 1'b0, ff_en = 1'b0;
    logic [6:0]  vl_in = '0, mvl_in = '0;
    logic [63:0] fault_vec = '0, zero_vec = '0;
    logic        elem_valid = 1'b0, elem_fault = 1'b0, elem_zero = 1'b0;
    logic        busy, done;
    logic [6:0]  vl_out;
    logic [63:0] commit_mask;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fof_truncator dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bulk(bulk),
        .mode_alu(mode_alu), .ff_en(ff_en), .vl_in(vl_in), .mvl_in(mvl_in),
        .fault_vec(fault_vec), .zero_vec(zero_vec),
        .elem_valid(elem_valid), .elem_fault(elem_fault), .elem_zero(elem_zero),
        .busy(busy), .done(done), .vl_out(vl_out), .commit_mask(commit_mask)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(int vl, int mvl, bit alu, bit ff,
                                   logic [63:0] flt, logic [63:0] zr);
        int lim = (vl < mvl) ? vl : mvl;
        if (lim > 64) lim = 64;
        if (ff) begin
            for (int i = 0; i < lim; i++) begin
                if (alu ? zr[i] : flt[i]) return i;
            end
        end
        return lim;
    endfunction

    function automatic logic [63:0] exp_mask(int len);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++) m[i] = (i < len);
        return m;
    endfunction

    task automatic run_bulk(input string req, input int vl, input int mvl, input bit alu,
                            input bit ff, input logic [63:0] flt, input logic [63:0] zr);
        int e = exp_len(vl, mvl, alu, ff, flt, zr);
        @(negedge clk);
        start = 1; bulk = 1; mode_alu = alu; ff_en = ff;
        vl_in = 7'(vl); mvl_in = 7'(mvl); fault_vec = flt; zero_vec = zr;
        @(negedge clk);
        start = 0; fault_vec = '0; zero_vec = '0;
        chk(done == 1'b1, "R8", "done after bulk start", 64'(done), 64'd1);
        chk(vl_out == 7'(e), req, "bulk vl_out", 64'(vl_out), 64'(e));
        chk(commit_mask == exp_mask(e), "R7", "bulk mask", commit_mask, exp_mask(e));
        @(negedge clk);
        chk(done == 1'b0 && vl_out == 7'(e), "R10", "pulse ends, vl held",
            {56'd0, done, vl_out}, 64'(e));
    endtask

    task automatic run_stream(input string req, input int vl, input int mvl, input bit alu,
                              input bit ff, input logic [63:0] flt, input logic [63:0] zr,
                              input bit poke_start);
        int e = exp_len(vl, mvl, alu, ff, flt, zr);
        int lim = (vl < mvl) ? vl : mvl;
        int exp_sent = (e < lim) ? e + 1 : lim;
        int sent = 0;
        @(negedge clk);
        start = 1; bulk = 0; mode_alu = alu; ff_en = ff;
        vl_in = 7'(vl); mvl_in = 7'(mvl);
        @(negedge clk);
        start = 0;
        while (!done && sent < 64) begin
            elem_valid = 1; elem_fault = flt[sent]; elem_zero = zr[sent];
            if (poke_start && sent == 1) begin
                start = 1; bulk = 1; vl_in = 7'd1; mvl_in = 7'd1;
            end
            @(negedge clk);
            elem_valid = 0; start = 0;
            sent++;
        end
        chk(done == 1'b1, "R9", "stream done", 64'(done), 64'd1);
        chk(sent == exp_sent, "R9", "elements consumed", 64'(sent), 64'(exp_sent));
        chk(vl_out == 7'(e), req, "stream vl_out", 64'(vl_out), 64'(e));
        chk(commit_mask == exp_mask(e), "R7", "stream mask", commit_mask, exp_mask(e));
        @(negedge clk);
        chk(done == 1'b0, "R10", "stream pulse ends", 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R12", "busy/done after reset", {62'd0, busy, done}, 64'd0);
        chk(vl_out == 0 && commit_mask == 0, "R12", "vl/mask after reset",
            commit_mask | 64'(vl_out), 64'd0);
    endtask

    task automatic t_load_first_fault;
        run_bulk("R2", 20, 64, 0, 1, 64'h1020, 64'h4);
    endtask
    task automatic t_alu_first_zero;
        run_bulk("R3", 30, 40, 1, 1, 64'h2, 64'h200 | 64'h1000);
    endtask
    task automatic t_fail_at_zero;
        run_bulk("R6", 16, 64, 0, 1, 64'h1, 64'h0);
        chk(commit_mask == 0 && vl_out == 0, "R6", "element 0 failure", commit_mask, 64'd0);
    endtask
    task automatic t_beyond_limit;
        run_bulk("R5", 10, 64, 0, 1, (64'd1 << 10) | (64'd1 << 40), 64'h0);
        run_bulk("R5", 10, 64, 1, 1, 64'h0, 64'd1 << 63);
    endtask
    task automatic t_disabled;
        run_bulk("R4", 25, 64, 0, 0, 64'hFFFF, 64'hFFFF);
        run_bulk("R4", 25, 64, 1, 0, 64'h0, 64'h1);
    endtask
    task automatic t_clamp;
        run_bulk("R1", 50, 30, 0, 1, 64'd1 << 35, 64'h0);
        run_bulk("R1", 64, 64, 1, 1, 64'h0, 64'h0);
        run_bulk("R1", 100, 120, 0, 0, 64'h0, 64'h0);
    endtask
    task automatic t_stream_load;
        run_stream("R2", 16, 64, 0, 1, 64'h80 | 64'h400, 64'h1, 0);
    endtask
    task automatic t_stream_alu;
        run_stream("R3", 20, 64, 1, 1, 64'h1, 64'h8, 0);
    endtask
    task automatic t_stream_full;
        run_stream("R1", 12, 40, 0, 1, 64'd1 << 12, 64'h0, 0);
    endtask
    task automatic t_stream_empty;
        run_stream("R9", 0, 64, 0, 1, 64'h1, 64'h0, 0);
    endtask
    task automatic t_start_while_busy;
        run_stream("R11", 9, 64, 0, 1, 64'h20, 64'h0, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_first_fault();
        t_alu_first_zero();
        t_fail_at_zero();
        t_beyond_limit();
        t_disabled();
        t_clamp();
        t_stream_load();
        t_stream_alu();
        t_stream_full();
        t_stream_empty();
        t_start_while_busy();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule